// File: doc/BRIEF.md
# Embedded Sync Video Stream Decoder

This block takes a multiplexed 4:2:2 byte stream, one byte per clock qualified by `in_valid`, in which luma and chroma samples are interleaved as Cb, Y, Cr, Y. Horizontal and vertical timing are not carried on separate wires. Instead, each line boundary is marked by a four-byte timing code: 0xFF, 0x00, 0x00, then a status byte. The decoder finds these codes and latches three timing flags from each status byte: the field flag, the vertical blanking flag and the horizontal flag. The horizontal flag also tells whether the code starts or ends active video. For each code it raises a one-cycle start or end pulse.

A byte-phase counter tracks the sample cadence. The first byte of every code falls where a Cb sample would fall. A start code forces the counter back to zero, so the next byte is taken as Cb. While the stream is inside active video on a non-blanked line, every completed group of four bytes is delivered as a pixel pair (Cb, Y0, Cr, Y1) with a one-cycle valid strobe.

The code detector is a four-state machine:
- `TRC_IDLE` moves to `TRC_FF` on 0xFF.
- `TRC_FF` moves to `TRC_Z1` on 0x00, stays in place on another 0xFF, and returns to idle on any other byte.
- `TRC_Z1` moves to `TRC_Z2` on 0x00, goes to `TRC_FF` on 0xFF, and returns to idle otherwise.
- `TRC_Z2` always returns to `TRC_IDLE` and takes the byte it accepts as the status byte.

Top module: `embsync_decoder`

## Requirements
- R1: After the byte sequence 0xFF, 0x00, 0x00, S is accepted, `fld`, `vblank` and `hsync` take S bit 6, S bit 5 and S bit 4 respectively. They change on the clock edge that accepts S.
- R2: Status bit 7 and status bits 3..0 have no effect on any output.
- R3: On the edge that accepts S, exactly one pulse is raised for exactly one cycle: `eav_pulse` if S bit 4 is 1, or `sav_pulse` if S bit 4 is 0.
- R4: `fld`, `vblank` and `hsync` hold their values until the next status byte is accepted.
- R5: Bytes are taken in the order Cb, Y0, Cr, Y1. On the edge that accepts Y1, `pix_valid` pulses for one cycle with all four samples on the pixel outputs, provided the stream is in active video.
- R6: Active video starts with a start code whose S bit 5 is 0 and ends with an end code. After a start code with S bit 5 set to 1, no pixel pair is produced.
- R7: A start code resets the byte phase, so the following byte is taken as Cb, whatever the phase was before the code.
- R8: A 0xFF that is not followed by 0x00, 0x00 returns the detector to idle. In that case all the bytes are handled as ordinary sample data.
- R9: A cycle with `in_valid` low changes no state, and `pix_valid` stays low.
- R10: While `rst` is high at a clock edge, all flags, pulses, the phase counter, active tracking and the detector are cleared.
- R11: The status byte of a code never completes a pixel pair, even when it lands in the Y1 slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Stream byte |
| fld | output | 1 | Latched field flag |
| vblank | output | 1 | Latched vertical blanking flag |
| hsync | output | 1 | Latched horizontal flag (1 after an end code) |
| sav_pulse | output | 1 | One-cycle start-of-active pulse |
| eav_pulse | output | 1 | One-cycle end-of-active pulse |
| pix_valid | output | 1 | One-cycle pixel pair strobe |
| pix_cb | output | 8 | Cb of the pair |
| pix_y0 | output | 8 | First luma sample |
| pix_cr | output | 8 | Cr of the pair |
| pix_y1 | output | 8 | Second luma sample |

## Verification
The first collision is between two events that can fall on the same edge: completing a pixel pair and accepting a status byte. Because a code starts in the Cb slot, an end code sent in cadence puts its status byte exactly in the Y1 slot. The bench sends such a code during active video and expects `eav_pulse` high with `pix_valid` low on that edge. The second collision is a data Cb of 0xFF during active video. This byte briefly arms the detector in the same cycle the byte is captured as a sample. The bench expects a normal pixel pair and no pulse.

// File: rtl/embsync_pkg.sv
package embsync_pkg;
    typedef enum logic [1:0] {
        TRC_IDLE,
        TRC_FF,
        TRC_Z1,
        TRC_Z2
    } trc_state_t;

    typedef enum logic [1:0] {
        SLOT_CB = 2'd0,
        SLOT_Y0 = 2'd1,
        SLOT_CR = 2'd2,
        SLOT_Y1 = 2'd3
    } slot_t;
endpackage

// File: rtl/embsync_trc_det.sv
module embsync_trc_det
    import embsync_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_byte,
    output logic         status_now,
    output logic         fld,
    output logic         vblank,
    output logic         hsync,
    output logic         sav_pulse,
    output logic         eav_pulse
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ALL_ZERO = '0;
    localparam int F_BIT = W - 2;
    localparam int V_BIT = W - 3;
    localparam int H_BIT = W - 4;

    trc_state_t state, state_nx;

    assign status_now = in_valid && (state == TRC_Z2);

    always_ff @(posedge clk) begin
        if (rst) state <= TRC_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (in_valid) begin
            unique case (state)
                TRC_IDLE: state_nx = (in_byte == ALL_ONES) ? TRC_FF : TRC_IDLE;
                TRC_FF:   state_nx = (in_byte == ALL_ZERO) ? TRC_Z1 :
                                     (in_byte == ALL_ONES) ? TRC_FF : TRC_IDLE;
                TRC_Z1:   state_nx = (in_byte == ALL_ZERO) ? TRC_Z2 :
                                     (in_byte == ALL_ONES) ? TRC_FF : TRC_IDLE;
                TRC_Z2:   state_nx = TRC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fld       <= 1'b0;
            vblank    <= 1'b0;
            hsync     <= 1'b0;
            sav_pulse <= 1'b0;
            eav_pulse <= 1'b0;
        end else begin
            sav_pulse <= 1'b0;
            eav_pulse <= 1'b0;
            if (status_now) begin
                fld       <= in_byte[F_BIT];
                vblank    <= in_byte[V_BIT];
                hsync     <= in_byte[H_BIT];
                sav_pulse <= !in_byte[H_BIT];
                eav_pulse <= in_byte[H_BIT];
            end
        end
    end

    assert_one_cycle_sav_R3: assert property (@(posedge clk) disable iff (rst)
        sav_pulse |=> !sav_pulse);
    assert_one_cycle_eav_R3: assert property (@(posedge clk) disable iff (rst)
        eav_pulse |=> !eav_pulse);
    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(sav_pulse || eav_pulse) |-> ($stable(fld) && $stable(vblank) && $stable(hsync)));
    assert_status_ends_code_R1: assert property (@(posedge clk) disable iff (rst)
        (state == TRC_Z2 && in_valid) |=> (state == TRC_IDLE));
    assert_broken_prefix_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (state == TRC_FF && in_valid && in_byte != ALL_ONES && in_byte != ALL_ZERO)
        |=> (state == TRC_IDLE));
    assert_no_valid_no_move_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(state) && !sav_pulse && !eav_pulse));
endmodule

// File: rtl/embsync_demux.sv
module embsync_demux
    import embsync_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_byte,
    input  logic         status_now,
    output logic [1:0]   phase,
    output logic         pix_valid,
    output logic [W-1:0] pix_cb,
    output logic [W-1:0] pix_y0,
    output logic [W-1:0] pix_cr,
    output logic [W-1:0] pix_y1
);
    localparam int NHOLD = 3;
    localparam int V_BIT = W - 3;
    localparam int H_BIT = W - 4;

    logic [W-1:0] hold [NHOLD];
    logic         active;
    logic         last_slot;

    assign last_slot = (phase == SLOT_Y1);

    for (genvar g = 0; g < NHOLD; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) hold[g] <= '0;
            else if (in_valid && !status_now && phase == 2'(g)) hold[g] <= in_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= SLOT_CB;
            active <= 1'b0;
        end else if (in_valid) begin
            if (status_now) begin
                active <= !in_byte[H_BIT] && !in_byte[V_BIT];
                phase  <= in_byte[H_BIT] ? phase + 2'd1 : SLOT_CB;
            end else begin
                phase  <= phase + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix_cb    <= '0;
            pix_y0    <= '0;
            pix_cr    <= '0;
            pix_y1    <= '0;
        end else begin
            pix_valid <= 1'b0;
            if (in_valid && last_slot && active && !status_now) begin
                pix_valid <= 1'b1;
                pix_cb    <= hold[SLOT_CB];
                pix_y0    <= hold[SLOT_Y0];
                pix_cr    <= hold[SLOT_CR];
                pix_y1    <= in_byte;
            end
        end
    end

    assert_pix_single_R5: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> !pix_valid);
    assert_idle_no_pix_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!pix_valid && $stable(phase)));
endmodule

// File: rtl/embsync_decoder.sv
module embsync_decoder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_byte,
    output logic         fld,
    output logic         vblank,
    output logic         hsync,
    output logic         sav_pulse,
    output logic         eav_pulse,
    output logic         pix_valid,
    output logic [W-1:0] pix_cb,
    output logic [W-1:0] pix_y0,
    output logic [W-1:0] pix_cr,
    output logic [W-1:0] pix_y1
);
    logic       status_now;
    logic [1:0] phase;

    embsync_trc_det #(.W(W)) u_det (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .status_now (status_now),
        .fld        (fld),
        .vblank     (vblank),
        .hsync      (hsync),
        .sav_pulse  (sav_pulse),
        .eav_pulse  (eav_pulse)
    );

    embsync_demux #(.W(W)) u_dmx (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .status_now (status_now),
        .phase      (phase),
        .pix_valid  (pix_valid),
        .pix_cb     (pix_cb),
        .pix_y0     (pix_y0),
        .pix_cr     (pix_cr),
        .pix_y1     (pix_y1)
    );

    assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(sav_pulse && eav_pulse));
    assert_sav_realigns_R7: assert property (@(posedge clk) disable iff (rst)
        sav_pulse |-> (phase == 2'd0));
    assert_no_pix_in_blank_R6: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (!vblank && !hsync));
    assert_code_not_pixel_R11: assert property (@(posedge clk) disable iff (rst)
        eav_pulse |-> !pix_valid);
endmodule

// File: tb/sim_embsync_decoder.sv
module sim_embsync_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       fld, vblank, hsync, sav_pulse, eav_pulse, pix_valid;
    logic [7:0] pix_cb, pix_y0, pix_cr, pix_y1;
    int nvec = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    embsync_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .fld(fld), .vblank(vblank), .hsync(hsync),
        .sav_pulse(sav_pulse), .eav_pulse(eav_pulse), .pix_valid(pix_valid),
        .pix_cb(pix_cb), .pix_y0(pix_y0), .pix_cr(pix_cr), .pix_y1(pix_y1)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        nvec++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
    endtask

    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hA5;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // send a full code and check flags and pulses on the status edge
    task automatic code(input string req, input logic [7:0] s);
        send(8'hFF); send(8'h00); send(8'h00);
        chk(req, "pix_valid before status", pix_valid, 0);
        send(s);
        chk(req, "fld", fld, s[6]);
        chk(req, "vblank", vblank, s[5]);
        chk(req, "hsync", hsync, s[4]);
        chk(req, "sav_pulse", sav_pulse, !s[4]);
        chk(req, "eav_pulse", eav_pulse, s[4]);
        chk(req, "pix_valid on status", pix_valid, 0);
    endtask

    task automatic group(input string req, input logic [7:0] cb, y0, cr, y1, input bit exp);
        send(cb); chk(req, "pv slot0", pix_valid, 0);
        send(y0); chk(req, "pv slot1", pix_valid, 0);
        send(cr); chk(req, "pv slot2", pix_valid, 0);
        send(y1);
        chk(req, "pix_valid", pix_valid, exp);
        if (exp) begin
            chk(req, "cb", pix_cb, cb);
            chk(req, "y0", pix_y0, y0);
            chk(req, "cr", pix_cr, cr);
            chk(req, "y1", pix_y1, y1);
        end
    endtask

    task automatic t_reset();
        chk("R10", "fld", fld, 0);
        chk("R10", "vblank", vblank, 0);
        chk("R10", "hsync", hsync, 0);
        chk("R10", "pulses", sav_pulse | eav_pulse, 0);
        chk("R10", "pix_valid", pix_valid, 0);
    endtask

    task automatic t_inactive_data();
        group("R6", 8'h11, 8'h22, 8'h33, 8'h44, 1'b0);
    endtask

    task automatic t_start_and_pixels();
        code("R1", 8'h8A);             // R2: bit7 and low nibble set, S = start, F=0 V=0
        send(8'h10);
        chk("R3", "sav_pulse drops", sav_pulse, 0);
        send(8'h20); send(8'h30); send(8'h40);
        chk("R5", "pix_valid", pix_valid, 1);
        chk("R5", "cb", pix_cb, 8'h10);
        chk("R5", "y0", pix_y0, 8'h20);
        chk("R5", "cr", pix_cr, 8'h30);
        chk("R5", "y1", pix_y1, 8'h40);
        gap();
        chk("R5", "pix_valid one cycle", pix_valid, 0);
        group("R5", 8'h81, 8'h7E, 8'h6F, 8'hEB, 1'b1);
        chk("R4", "flags held", {fld, vblank, hsync}, 3'b000);
    endtask

    task automatic t_false_ff();
        group("R8", 8'hFF, 8'h00, 8'h12, 8'h34, 1'b1);
        chk("R8", "no pulse", sav_pulse | eav_pulse, 0);
        group("R8", 8'hFF, 8'hFF, 8'h00, 8'h56, 1'b1);
        chk("R4", "flags held", {fld, vblank, hsync}, 3'b000);
    endtask

    task automatic t_gaps();
        send(8'h0A); gap(); send(8'h0B); gap();
        chk("R9", "pv in gap", pix_valid, 0);
        send(8'h0C); gap(); gap(); send(8'h0D);
        chk("R9", "pix_valid", pix_valid, 1);
        chk("R9", "cb", pix_cb, 8'h0A);
        chk("R9", "y1", pix_y1, 8'h0D);
        gap();
        chk("R9", "pv after gap", pix_valid, 0);
    endtask

    task automatic t_eav_in_cadence();
        code("R11", 8'h9F);            // end code, status lands in Y1 slot
        group("R6", 8'h01, 8'h02, 8'h03, 8'h04, 1'b0);
    endtask

    task automatic t_realign_field2();
        send(8'h77);                   // phase now off by one
        code("R7", 8'h4F);             // field 2 start, low nibble set (R2)
        group("R7", 8'hC1, 8'hC2, 8'hC3, 8'hC4, 1'b1);
    endtask

    task automatic t_blank_start();
        code("R6", 8'hA0);             // start with V=1
        group("R6", 8'h50, 8'h51, 8'h52, 8'h53, 1'b0);
        code("R2", 8'h3F);             // end, V=1, noise bits
        code("R2", 8'hC0);             // start, F=1, bit7 set
        chk("R2", "flags", {fld, vblank, hsync}, 3'b100);
    endtask

    task automatic t_reset_mid_code();
        send(8'hFF); send(8'h00);
        do_reset();
        #1;
        chk("R10", "fld cleared", fld, 0);
        send(8'h00); send(8'h00);
        chk("R10", "no sav after reset", sav_pulse, 0);
        chk("R10", "pix_valid", pix_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        t_reset();
        t_inactive_data();
        t_start_and_pixels();
        t_false_ff();
        t_gaps();
        t_eav_in_cadence();
        t_realign_field2();
        t_blank_start();
        t_reset_mid_code();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule